// File: doc/BRIEF.md
# Priority-Class Header Rule Classifier

This block sorts packets by matching header fields against rule sets. The fields are source address, destination address, source port, destination port and protocol, and they are joined in that order into one search key. Rules are grouped into a small fixed number of priority classes. Each class owns a separate decision-diagram walk: a chain of node tables, one per key bit. At each level the current node pointer and one key bit choose the next node. A leaf table at the end gives a match flag and an action code for that class.

All class pipelines take the same key in the same cycle and have the same depth, so their results arrive together. A registered selector then outputs the action of the highest-numbered class that matched. If no class matched, it outputs a default action with the match flag low. The tables are loaded through one write port, which is addressed by class, level and word. Compiling rules into node words happens outside the block. That includes choosing which rule wins when several rules in one class match.

Top module: `rule_classifier_top`

## Requirements
- R1: The search key is {src addr, dst addr, src port, dst port, proto}. Its top bit (the source-address MSB) is consumed at level 0 and the protocol LSB at level KEY_W-1.
- R2: Each of the NUM_CLS classes has its own tables. A table write touches only the class given by tbl_class, and all classes process the same key in parallel.
- R3: Class NUM_CLS-1 has the highest priority and class 0 the lowest. When at least one class matches, out_hit=1, out_class is the highest matching class index, and out_action is that class's leaf action.
- R4: When a valid packet matches in no class, out_hit=0, out_class=0 and out_action=DEFAULT_ACT (0 by default).
- R5: out_valid rises exactly KEY_W+2 cycles (18 with the defaults) after in_valid is sampled high. A new header is accepted every cycle and results stay in order.
- R6: In any cycle where out_valid=0, out_hit=0, out_class=0 and out_action=DEFAULT_ACT.
- R7: While rst_n is low, out_valid=0, out_hit=0, out_class=0 and out_action=DEFAULT_ACT.
- R8: Table format for levels L < KEY_W: the word at tbl_addr = {pointer, key bit} holds the next pointer in tbl_data[PTR_W-1:0], and the root pointer is 0. Level KEY_W is the leaf table: the word at address pointer (tbl_addr[PTR_W-1:0]) holds the hit flag in bit ACT_W and the action in bits ACT_W-1:0.
- R9: Within one class, when several rules match, the leaf word alone decides which action is reported. The selector never arbitrates inside a class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Header present this cycle |
| in_src_addr | input | SA_W | Source address field |
| in_dst_addr | input | DA_W | Destination address field |
| in_src_port | input | SP_W | Source port field |
| in_dst_port | input | DP_W | Destination port field |
| in_proto | input | PR_W | Protocol field |
| tbl_we | input | 1 | Table write strobe |
| tbl_class | input | CLS_W | Class whose table is written |
| tbl_level | input | LVL_W | Level 0..KEY_W-1 for node words, KEY_W for the leaf table |
| tbl_addr | input | PTR_W+1 | Word address within the level |
| tbl_data | input | DATA_W | Word written |
| out_valid | output | 1 | Result present |
| out_hit | output | 1 | Some class matched |
| out_class | output | CLS_W | Winning class index |
| out_action | output | ACT_W | Selected action code |

## Verification
Random rule sets with mixed prefix lengths are driven with two kinds of key. Some keys are drawn uniformly, and these mostly miss. Others are built from a stored rule with random bits in its wildcard positions, so they hit one or more classes at once. Comparing these two kinds separates priority selection from the default path. Keys that hit several rules inside one class show whether the leaf word or the selector decides the result. A table set with no enabled rule, and one with a catch-all rule in class 0, exercise the never-match and always-match extremes. A set with one rule that tests only the top key bit, probed with single-bit keys at both ends, shows whether the key bits are walked in the correct order. Random gaps in in_valid check that results stay aligned and that idle cycles stay quiet.

// File: rtl/rule_cls_pkg.sv
package rule_cls_pkg;

  // index of the most significant set bit, 0 when none is set
  function automatic int unsigned top_set_index(input logic [31:0] vec);
    int unsigned idx;
    idx = 0;
    for (int i = 0; i < 32; i++) begin
      if (vec[i]) idx = i;
    end
    return idx;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // key bits left to walk when a level is entered
  function automatic int unsigned bits_left(input int unsigned level, input int unsigned key_w);
    return key_w - level;
  endfunction

endpackage

// File: rtl/dd_walk_pipe.sv
module dd_walk_pipe
  import rule_cls_pkg::*;
#(
  parameter int unsigned KEY_W  = 16,
  parameter int unsigned PTR_W  = 3,
  parameter int unsigned ACT_W  = 4,
  parameter int unsigned LVL_W  = 5,
  parameter int unsigned DATA_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [KEY_W-1:0]  in_key,
  input  logic              wr_en,
  input  logic [LVL_W-1:0]  wr_level,
  input  logic [PTR_W:0]    wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              res_valid,
  output logic              res_hit,
  output logic [ACT_W-1:0]  res_act
);

  localparam int unsigned NODE_WORDS = 2 ** (PTR_W + 1);
  localparam int unsigned LEAF_WORDS = 2 ** PTR_W;

  for (genvar lv = 0; lv < KEY_W; lv++) begin : stg
    localparam int unsigned REM = bits_left(lv, KEY_W);

    logic [PTR_W-1:0] ptr_in;
    logic [PTR_W-1:0] ptr_q;
    logic [REM-1:0]   key_in;
    logic             v_in;
    logic             v_q;
    logic [PTR_W:0]   rd_addr;
    logic [PTR_W-1:0] node_mem [NODE_WORDS];

    if (lv == 0) begin : g_head
      assign ptr_in = '0;
      assign key_in = in_key;
      assign v_in   = in_valid;
    end else begin : g_link
      assign ptr_in = stg[lv-1].ptr_q;
      assign key_in = stg[lv-1].g_carry.key_q;
      assign v_in   = stg[lv-1].v_q;
    end

    // node word address: current pointer with the key bit of this level
    assign rd_addr = {ptr_in, key_in[REM-1]};

    always_ff @(posedge clk) begin
      if (wr_en && (wr_level == LVL_W'(lv))) begin
        node_mem[wr_addr] <= wr_data[PTR_W-1:0];
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q   <= 1'b0;
        ptr_q <= '0;
      end else begin
        v_q   <= v_in;
        ptr_q <= node_mem[rd_addr];
      end
    end

    if (REM > 1) begin : g_carry
      logic [REM-2:0] key_q;
      always_ff @(posedge clk) begin
        if (!rst_n) key_q <= '0;
        else        key_q <= key_in[REM-2:0];
      end
    end
  end

  // leaf table: {hit, action} per final pointer
  logic [ACT_W:0] leaf_mem [LEAF_WORDS];
  logic [ACT_W:0] leaf_word;
  logic           leaf_v;
  logic           leaf_hit;

  always_ff @(posedge clk) begin
    if (wr_en && (wr_level == LVL_W'(KEY_W))) begin
      leaf_mem[wr_addr[PTR_W-1:0]] <= wr_data[ACT_W:0];
    end
  end

  assign leaf_word = leaf_mem[stg[KEY_W-1].ptr_q];
  assign leaf_v    = stg[KEY_W-1].v_q;
  assign leaf_hit  = leaf_v && leaf_word[ACT_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_act   <= '0;
    end else begin
      res_valid <= leaf_v;
      res_hit   <= leaf_hit;
      res_act   <= leaf_hit ? leaf_word[ACT_W-1:0] : '0;
    end
  end

endmodule

// File: rtl/prio_pick.sv
module prio_pick
  import rule_cls_pkg::*;
#(
  parameter int unsigned NUM_CLS     = 4,
  parameter int unsigned CLS_W       = 2,
  parameter int unsigned ACT_W       = 4,
  parameter int unsigned DEFAULT_ACT = 0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     grp_valid,
  input  logic [NUM_CLS-1:0]       cls_hit,
  input  logic [NUM_CLS*ACT_W-1:0] cls_act,
  output logic                     out_valid,
  output logic                     out_hit,
  output logic [CLS_W-1:0]         out_class,
  output logic [ACT_W-1:0]         out_action
);

  logic [CLS_W-1:0] win_idx;
  logic             any_hit;
  logic [ACT_W-1:0] win_act;

  assign win_idx = CLS_W'(top_set_index(32'(cls_hit)));
  assign any_hit = |cls_hit;
  assign win_act = cls_act[win_idx*ACT_W +: ACT_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_hit    <= 1'b0;
      out_class  <= '0;
      out_action <= ACT_W'(DEFAULT_ACT);
    end else begin
      out_valid  <= grp_valid;
      out_hit    <= grp_valid && any_hit;
      out_class  <= (grp_valid && any_hit) ? win_idx : '0;
      out_action <= (grp_valid && any_hit) ? win_act : ACT_W'(DEFAULT_ACT);
    end
  end

endmodule

// File: rtl/rule_classifier_top.sv
module rule_classifier_top
  import rule_cls_pkg::*;
#(
  parameter int unsigned SA_W        = 4,
  parameter int unsigned DA_W        = 4,
  parameter int unsigned SP_W        = 3,
  parameter int unsigned DP_W        = 3,
  parameter int unsigned PR_W        = 2,
  parameter int unsigned NUM_CLS     = 4,
  parameter int unsigned PTR_W       = 3,
  parameter int unsigned ACT_W       = 4,
  parameter int unsigned DEFAULT_ACT = 0,
  localparam int unsigned KEY_W  = SA_W + DA_W + SP_W + DP_W + PR_W,
  localparam int unsigned CLS_W  = (NUM_CLS > 1) ? $clog2(NUM_CLS) : 1,
  localparam int unsigned LVL_W  = $clog2(KEY_W + 1),
  localparam int unsigned DATA_W = max_u(PTR_W, ACT_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [SA_W-1:0]   in_src_addr,
  input  logic [DA_W-1:0]   in_dst_addr,
  input  logic [SP_W-1:0]   in_src_port,
  input  logic [DP_W-1:0]   in_dst_port,
  input  logic [PR_W-1:0]   in_proto,
  input  logic              tbl_we,
  input  logic [CLS_W-1:0]  tbl_class,
  input  logic [LVL_W-1:0]  tbl_level,
  input  logic [PTR_W:0]    tbl_addr,
  input  logic [DATA_W-1:0] tbl_data,
  output logic              out_valid,
  output logic              out_hit,
  output logic [CLS_W-1:0]  out_class,
  output logic [ACT_W-1:0]  out_action
);

  // search key, walked from its MSB down
  logic [KEY_W-1:0]         hdr_key;
  logic [NUM_CLS-1:0]       cls_valid;
  logic [NUM_CLS-1:0]       cls_hit;
  logic [NUM_CLS*ACT_W-1:0] cls_act;
  logic                     grp_valid;

  assign hdr_key = {in_src_addr, in_dst_addr, in_src_port, in_dst_port, in_proto};

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    logic cls_we;
    assign cls_we = tbl_we && (tbl_class == CLS_W'(c));

    dd_walk_pipe #(
      .KEY_W (KEY_W),
      .PTR_W (PTR_W),
      .ACT_W (ACT_W),
      .LVL_W (LVL_W),
      .DATA_W(DATA_W)
    ) pipe_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_key   (hdr_key),
      .wr_en    (cls_we),
      .wr_level (tbl_level),
      .wr_addr  (tbl_addr),
      .wr_data  (tbl_data),
      .res_valid(cls_valid[c]),
      .res_hit  (cls_hit[c]),
      .res_act  (cls_act[c*ACT_W +: ACT_W])
    );
  end

  assign grp_valid = &cls_valid;

  prio_pick #(
    .NUM_CLS    (NUM_CLS),
    .CLS_W      (CLS_W),
    .ACT_W      (ACT_W),
    .DEFAULT_ACT(DEFAULT_ACT)
  ) pick_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .grp_valid (grp_valid),
    .cls_hit   (cls_hit),
    .cls_act   (cls_act),
    .out_valid (out_valid),
    .out_hit   (out_hit),
    .out_class (out_class),
    .out_action(out_action)
  );

endmodule

// File: rtl/rule_classifier_chk.sv
module rule_classifier_chk #(
  parameter int unsigned NUM_CLS     = 4,
  parameter int unsigned CLS_W       = 2,
  parameter int unsigned ACT_W       = 4,
  parameter int unsigned DEFAULT_ACT = 0
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_CLS-1:0]       cls_valid,
  input logic [NUM_CLS-1:0]       cls_hit,
  input logic [NUM_CLS*ACT_W-1:0] cls_act,
  input logic                     out_valid,
  input logic                     out_hit,
  input logic [CLS_W-1:0]         out_class,
  input logic [ACT_W-1:0]         out_action
);

  logic [NUM_CLS-1:0]       hit_d;
  logic [NUM_CLS*ACT_W-1:0] act_d;
  logic                     vld_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_d <= '0;
      act_d <= '0;
      vld_d <= 1'b0;
    end else begin
      hit_d <= cls_hit;
      act_d <= cls_act;
      vld_d <= cls_valid[0];
    end
  end

  // per-class pipelines stay in step (R5)
  assert_cls_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_valid == '0) || (cls_valid == '1));

  assert_valid_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vld_d);

  assert_winner_matched_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_hit) |-> hit_d[out_class]);

  assert_no_higher_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_hit) |-> (((hit_d >> out_class) >> 1) == '0));

  assert_action_from_winner_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_hit) |-> (out_action == act_d[out_class*ACT_W +: ACT_W]));

  assert_hit_when_any_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_hit == (|hit_d));

  assert_miss_default_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_hit) |-> (out_action == ACT_W'(DEFAULT_ACT) && out_class == '0));

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_hit && out_class == '0 && out_action == ACT_W'(DEFAULT_ACT)));

endmodule

bind rule_classifier_top rule_classifier_chk #(
  .NUM_CLS    (NUM_CLS),
  .CLS_W      (CLS_W),
  .ACT_W      (ACT_W),
  .DEFAULT_ACT(DEFAULT_ACT)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cls_valid (cls_valid),
  .cls_hit   (cls_hit),
  .cls_act   (cls_act),
  .out_valid (out_valid),
  .out_hit   (out_hit),
  .out_class (out_class),
  .out_action(out_action)
);

// File: tb/rule_classifier_top_tb_top.sv
`timescale 1ns/1ps
module rule_classifier_top_tb_top;

  localparam int NCLS  = 4;
  localparam int NRULE = 3;
  localparam int KW    = 16;
  localparam int LAT   = KW + 2;
  localparam int HN    = 256;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [3:0] in_src_addr, in_dst_addr;
  logic [2:0] in_src_port, in_dst_port;
  logic [1:0] in_proto;
  logic       tbl_we;
  logic [1:0] tbl_class;
  logic [4:0] tbl_level;
  logic [3:0] tbl_addr;
  logic [4:0] tbl_data;
  logic       out_valid, out_hit;
  logic [1:0] out_class;
  logic [3:0] out_action;

  always #2.5 clk = ~clk;

  rule_classifier_top dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_src_addr(in_src_addr), .in_dst_addr(in_dst_addr),
    .in_src_port(in_src_port), .in_dst_port(in_dst_port), .in_proto(in_proto),
    .tbl_we(tbl_we), .tbl_class(tbl_class), .tbl_level(tbl_level),
    .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .out_valid(out_valid), .out_hit(out_hit), .out_class(out_class), .out_action(out_action)
  );

  // rule sets: value/care over the 16-bit key, action, enable
  logic [15:0] r_val  [NCLS][NRULE];
  logic [15:0] r_care [NCLS][NRULE];
  logic [3:0]  r_act  [NCLS][NRULE];
  logic        r_en   [NCLS][NRULE];

  logic       h_v   [HN];
  logic       h_hit [HN];
  logic [1:0] h_cls [HN];
  logic [3:0] h_act [HN];

  int  cyc = 0;
  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done = 1'b0;

  task automatic chk(input string req, input string what, input int actual, input int expected);
    n_cmp++;
    if (actual != expected) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, actual, expected, cyc);
    end
  endtask

  // reference: scan classes from highest priority, rules in index order (R3, R9)
  task automatic model(input logic [15:0] k, output logic hit, output logic [1:0] cls,
                       output logic [3:0] act);
    hit = 1'b0; cls = 2'd0; act = 4'd0;
    for (int c = NCLS - 1; c >= 0; c--) begin
      for (int r = 0; r < NRULE; r++) begin
        if (!hit && r_en[c][r] && (((k ^ r_val[c][r]) & r_care[c][r]) == 16'h0)) begin
          hit = 1'b1; cls = 2'(c); act = r_act[c][r];
        end
      end
    end
  endtask

  task automatic tick(input logic v, input logic [15:0] k, input logic we,
                      input logic [1:0] wc, input logic [4:0] wl, input logic [3:0] wa,
                      input logic [4:0] wd);
    logic mh; logic [1:0] mc; logic [3:0] ma;
    @(negedge clk);
    if (cyc >= LAT) begin
      int i;
      i = (cyc - LAT) % HN;
      chk("R5", "out_valid", out_valid, h_v[i]);
      if (!h_v[i]) begin
        chk("R6", "idle out_hit", out_hit, 0);
        chk("R6", "idle out_action", out_action, 0);
      end else if (h_hit[i]) begin
        chk("R1 R3", "out_hit", out_hit, 1);
        chk("R2 R3", "out_class", out_class, h_cls[i]);
        chk("R3 R8 R9", "out_action", out_action, h_act[i]);
      end else begin
        chk("R4", "miss out_hit", out_hit, 0);
        chk("R4", "miss out_class", out_class, 0);
        chk("R4", "miss out_action", out_action, 0);
      end
    end
    in_valid = v;
    {in_src_addr, in_dst_addr, in_src_port, in_dst_port, in_proto} = k;
    tbl_we = we; tbl_class = wc; tbl_level = wl; tbl_addr = wa; tbl_data = wd;
    model(k, mh, mc, ma);
    h_v[cyc % HN] = v; h_hit[cyc % HN] = v && mh;
    h_cls[cyc % HN] = mc; h_act[cyc % HN] = ma;
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 16'h0, 1'b0, 2'd0, 5'd0, 4'd0, 5'd0);
  endtask

  // compile rule sets into the R8 table format: pointer = complement of live-rule mask
  task automatic program_tables();
    idle(LAT + 2);
    for (int c = 0; c < NCLS; c++) begin
      for (int lv = 0; lv < KW; lv++) begin
        for (int a = 0; a < 16; a++) begin
          logic [2:0] live, keep, nxt;
          int bp;
          bp = KW - 1 - lv;
          live = ~3'(a >> 1);
          keep = '0;
          for (int r = 0; r < NRULE; r++) begin
            if (r_en[c][r] && (!r_care[c][r][bp] || (r_val[c][r][bp] == a[0]))) keep[r] = 1'b1;
          end
          nxt = ~(live & keep);
          tick(1'b0, 16'h0, 1'b1, 2'(c), 5'(lv), 4'(a), {2'b00, nxt});
        end
      end
      for (int p = 0; p < 8; p++) begin
        logic [2:0] live; logic [3:0] act; logic found;
        live = ~3'(p); act = 4'd0; found = 1'b0;
        for (int r = 0; r < NRULE; r++) begin
          if (!found && live[r]) begin found = 1'b1; act = r_act[c][r]; end
        end
        tick(1'b0, 16'h0, 1'b1, 2'(c), 5'(KW), 4'(p), {found, act});
      end
    end
    idle(2);
  endtask

  function automatic logic [15:0] prefix_care(input int w, input int len);
    logic [15:0] m;
    m = '0;
    for (int i = 0; i < len; i++) m[w - 1 - i] = 1'b1;
    return m;
  endfunction

  task automatic rand_rules(input bit all_off);
    int fw [5];
    fw = '{4, 4, 3, 3, 2};
    for (int c = 0; c < NCLS; c++) begin
      for (int r = 0; r < NRULE; r++) begin
        logic [15:0] care;
        care = '0;
        for (int f = 0; f < 5; f++) begin
          care = (care << fw[f]) | prefix_care(fw[f], int'($urandom % (fw[f] + 1)));
        end
        r_care[c][r] = care;
        r_val[c][r]  = 16'($urandom) & care;
        r_act[c][r]  = 4'($urandom);
        r_en[c][r]   = !all_off && (($urandom % 5) != 0);
      end
    end
  endtask

  function automatic logic [15:0] pick_key();
    int c, r;
    if ($urandom % 2 == 0) return 16'($urandom);
    c = int'($urandom % NCLS); r = int'($urandom % NRULE);
    return r_val[c][r] | (16'($urandom) & ~r_care[c][r]);
  endfunction

  task automatic traffic(input int n);
    for (int i = 0; i < n; i++) begin
      tick(($urandom % 7) != 0, pick_key(), 1'b0, 2'd0, 5'd0, 4'd0, 5'd0);
    end
  endtask

  initial begin
    void'($urandom(32'h1C0DE));
    for (int i = 0; i < HN; i++) begin h_v[i] = 0; h_hit[i] = 0; h_cls[i] = 0; h_act[i] = 0; end
    rst_n = 1'b0; in_valid = 1'b1;
    {in_src_addr, in_dst_addr, in_src_port, in_dst_port, in_proto} = 16'hFFFF;
    tbl_we = 1'b0; tbl_class = '0; tbl_level = '0; tbl_addr = '0; tbl_data = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R7: reset state while a header is presented
    chk("R7", "reset out_valid", out_valid, 0);
    chk("R7", "reset out_hit", out_hit, 0);
    chk("R7", "reset out_class", out_class, 0);
    chk("R7", "reset out_action", out_action, 0);
    in_valid = 1'b0;
    rst_n = 1'b1;

    // set A: random rule sets, several classes may match at once (R2 R3 R9)
    rand_rules(1'b0);
    program_tables();
    traffic(600);

    // set B: nothing enabled, every valid packet misses (R4)
    rand_rules(1'b1);
    program_tables();
    traffic(150);

    // set C: catch-all rule in class 0 under random higher classes (R3)
    rand_rules(1'b0);
    r_en[0][0] = 1'b1; r_care[0][0] = 16'h0; r_val[0][0] = 16'h0; r_act[0][0] = 4'hA;
    program_tables();
    traffic(500);

    // set D: single rule on the top key bit only, in class 2 (R1)
    rand_rules(1'b1);
    r_en[2][0] = 1'b1; r_care[2][0] = 16'h8000; r_val[2][0] = 16'h8000; r_act[2][0] = 4'h9;
    program_tables();
    tick(1'b1, 16'h8000, 1'b0, 2'd0, 5'd0, 4'd0, 5'd0);
    tick(1'b1, 16'h0001, 1'b0, 2'd0, 5'd0, 4'd0, 5'd0);
    tick(1'b1, 16'h7FFF, 1'b0, 2'd0, 5'd0, 4'd0, 5'd0);
    tick(1'b1, 16'hFFFF, 1'b0, 2'd0, 5'd0, 4'd0, 5'd0);
    traffic(100);

    // set E: back-to-back full-rate packets after another reload (R5 R8)
    rand_rules(1'b0);
    program_tables();
    for (int i = 0; i < 200; i++) tick(1'b1, pick_key(), 1'b0, 2'd0, 5'd0, 4'd0, 5'd0);
    idle(LAT + 2);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R5 watchdog expired actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule